// File: doc/BRIEF.md
# Trap entry and delay-slot sequencer

This block sits beside the retire stage of a pipelined processor whose control-transfer instructions have one architectural delay slot. It keeps two one-bit flags that tell whether the instruction now retiring occupies a delay slot. From those flags and from exception requests it produces everything that trap entry and trap return change architecturally. That covers the saved status, the saved PC, the faulting effective address, the previous-PC record, a status write-back word carrying the delay-slot marker, and a one-cycle fetch redirect to the handler or back to the interrupted code.

Requests arrive as single-cycle strobes. In any cycle an exception request wins over a return-from-exception, and a return-from-exception wins over a retire. A strobe that loses is ignored entirely. All outputs are registered, so each result appears one clock after the strobe that caused it. An unknown exception number, or a forbidden instruction retiring in a delay slot, raises a one-cycle error flag together with the offending PC.

Top module: `trap_seq`

## Requirements
- R1: On a winning retire, the in-slot flag (`in_dslot`) takes the value of the pending-slot flag, and the pending-slot flag is then cleared unless R2 sets it.
- R2: A winning retire with `retire_dly_cti` high sets the pending-slot flag, except when `no_dslot_cfg` is 1. The following retire then shows `in_dslot` = 1.
- R3: A winning retire with `retire_no_ds` high while the pending-slot flag is set pulses `err_flag` for one cycle, with `err_pc` equal to that retire's PC.
- R4: On entry with a known exception number, `esr` takes `status_in`. A status write is issued (`status_we`) of `status_in` with bit 13 (delay-slot marker) replaced by the faulting instruction's slot state. That state is the pending-slot flag, which also moves into `in_dslot`.
- R5: System call (code 0xC) loads `epcr` with PC+4 outside a delay slot and with PC inside one.
- R6: Bus error (0x2), alignment (0x6), illegal instruction (0x7), range (0xB) and trap (0xE) load `epcr` with PC outside a delay slot and with PC-4 inside one.
- R7: Reset (0x1) leaves `epcr` unchanged. Any other code pulses `err_flag` with `err_pc` = `exc_pc` and has no other effect: no redirect, no status write, and `esr`/`epcr` are unchanged.
- R8: An illegal-instruction exception (0x7) also loads `eear` with the faulting PC.
- R9: A known exception redirects fetch to code<<8, plus 0xF0000000 when status bit 14 (high vector base) is 1, and clears the pending-slot flag.
- R10: Return-from-exception issues a status write of `esr` with bit 15 (fixed-one) forced to 1, redirects fetch to `epcr`, and clears both slot flags.
- R11: Each winning retire records its PC in `ppc`.
- R12: Priority is exception over return over retire. The losing strobe in that cycle has no effect. `redirect_vld`, `status_we` and `err_flag` are single-cycle pulses, one clock after the causing strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_pc | input | AW | PC of the retiring instruction |
| retire_dly_cti | input | 1 | Retiring instruction is a delayed control transfer |
| retire_no_ds | input | 1 | Retiring instruction is forbidden in a delay slot |
| no_dslot_cfg | input | 1 | Configuration: core has no delay slots |
| exc_req | input | 1 | Exception request |
| exc_code | input | CW | Exception number |
| exc_pc | input | AW | PC of the faulting instruction |
| rfe_req | input | 1 | Return-from-exception strobe |
| status_in | input | SW | Current status register |
| esr | output | SW | Saved status |
| epcr | output | AW | Saved PC |
| eear | output | AW | Saved effective address |
| ppc | output | AW | Previous retired PC |
| status_we | output | 1 | Status write pulse |
| status_wdata | output | SW | Status write value |
| in_dslot | output | 1 | Last retired instruction was in a delay slot |
| redirect_vld | output | 1 | Fetch redirect pulse |
| redirect_pc | output | AW | Fetch redirect target |
| err_flag | output | 1 | Error pulse |
| err_pc | output | AW | PC tied to the error |

## Verification
The hardest situations to reach are those where a delay-slot instruction faults, or where a forbidden instruction lands in a slot. They need the pending-slot flag set by a delayed-transfer retire in the cycle just before, and that flag is visible only through its later effects. The directed tasks therefore retire a delayed transfer first, then present the exception or the forbidden retire on the next strobe, and read the slot state back through `epcr`, the status write word and `in_dslot`. Flag clearing by exception entry, by return and by a losing simultaneous retire is shown the same way, by a follow-up retire that must report `in_dslot` = 0.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned ST_FO_BIT  = 15;
  localparam int unsigned ST_EPH_BIT = 14;
  localparam int unsigned ST_DSX_BIT = 13;

  localparam logic [3:0] EXC_RESET   = 4'h1;
  localparam logic [3:0] EXC_BUSERR  = 4'h2;
  localparam logic [3:0] EXC_ALIGN   = 4'h6;
  localparam logic [3:0] EXC_ILLEGAL = 4'h7;
  localparam logic [3:0] EXC_RANGE   = 4'hB;
  localparam logic [3:0] EXC_SYSCALL = 4'hC;
  localparam logic [3:0] EXC_TRAP    = 4'hE;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_RESET = 2'd1,
    CLS_AFTER = 2'd2,
    CLS_AT    = 2'd3
  } exc_class_e;

  function automatic exc_class_e classify(input logic [3:0] code);
    case (code)
      EXC_RESET:   return CLS_RESET;
      EXC_SYSCALL: return CLS_AFTER;
      EXC_BUSERR, EXC_ALIGN, EXC_ILLEGAL, EXC_RANGE, EXC_TRAP: return CLS_AT;
      default:     return CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dslot_track.sv
module dslot_track (
  input  logic clk,
  input  logic rst,
  input  logic retire_step,
  input  logic retire_cti,
  input  logic retire_no_ds,
  input  logic no_dslot_cfg,
  input  logic exc_step,
  input  logic rfe_step,
  output logic in_q,
  output logic pend_q,
  output logic bad_slot
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (exc_step) begin
      in_q   <= pend_q;
      pend_q <= 1'b0;
    end else if (rfe_step) begin
      in_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (retire_step) begin
      in_q   <= pend_q;
      pend_q <= retire_cti & ~no_dslot_cfg;
    end
  end

  assign bad_slot = retire_step & pend_q & retire_no_ds;
endmodule

// File: rtl/trap_vec.sv
module trap_vec
  import trap_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned CW         = 4,
  parameter int unsigned VEC_SHIFT  = 8,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [AW-1:0] HI_BASE  = 32'hF000_0000
) (
  input  logic [CW-1:0] code,
  input  logic [AW-1:0] pc,
  input  logic          in_slot,
  input  logic          hi_vec,
  output logic          known,
  output logic          epc_load,
  output logic          is_illegal,
  output logic [AW-1:0] epc_val,
  output logic [AW-1:0] handler
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  exc_class_e cls;

  always_comb begin
    cls        = classify(4'(code));
    known      = (cls != CLS_NONE);
    epc_load   = (cls == CLS_AFTER) || (cls == CLS_AT);
    is_illegal = (4'(code) == EXC_ILLEGAL);
    epc_val    = pc;
    if (cls == CLS_AFTER)
      epc_val = in_slot ? pc : pc + STEP;
    else if (cls == CLS_AT)
      epc_val = in_slot ? pc - STEP : pc;
    handler = (hi_vec ? HI_BASE : '0) + (AW'(code) << VEC_SHIFT);
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned SW         = 16,
  parameter int unsigned CW         = 4,
  parameter int unsigned VEC_SHIFT  = 8,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [AW-1:0] HI_BASE  = 32'hF000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire_vld,
  input  logic [AW-1:0] retire_pc,
  input  logic          retire_dly_cti,
  input  logic          retire_no_ds,
  input  logic          no_dslot_cfg,
  input  logic          exc_req,
  input  logic [CW-1:0] exc_code,
  input  logic [AW-1:0] exc_pc,
  input  logic          rfe_req,
  input  logic [SW-1:0] status_in,
  output logic [SW-1:0] esr,
  output logic [AW-1:0] epcr,
  output logic [AW-1:0] eear,
  output logic [AW-1:0] ppc,
  output logic          status_we,
  output logic [SW-1:0] status_wdata,
  output logic          in_dslot,
  output logic          redirect_vld,
  output logic [AW-1:0] redirect_pc,
  output logic          err_flag,
  output logic [AW-1:0] err_pc
);
  logic          pend_ds;
  logic          bad_slot;
  logic          known;
  logic          epc_load;
  logic          is_illegal;
  logic [AW-1:0] epc_val;
  logic [AW-1:0] handler;
  logic          take_exc;
  logic          take_rfe;
  logic          take_ret;

  assign take_exc = exc_req & known;
  assign take_rfe = rfe_req & ~exc_req;
  assign take_ret = retire_vld & ~exc_req & ~rfe_req;

  dslot_track u_track (
    .clk          (clk),
    .rst          (rst),
    .retire_step  (take_ret),
    .retire_cti   (retire_dly_cti),
    .retire_no_ds (retire_no_ds),
    .no_dslot_cfg (no_dslot_cfg),
    .exc_step     (take_exc),
    .rfe_step     (take_rfe),
    .in_q         (in_dslot),
    .pend_q       (pend_ds),
    .bad_slot     (bad_slot)
  );

  trap_vec #(
    .AW(AW), .CW(CW), .VEC_SHIFT(VEC_SHIFT),
    .INSN_BYTES(INSN_BYTES), .HI_BASE(HI_BASE)
  ) u_vec (
    .code       (exc_code),
    .pc         (exc_pc),
    .in_slot    (pend_ds),
    .hi_vec     (status_in[ST_EPH_BIT]),
    .known      (known),
    .epc_load   (epc_load),
    .is_illegal (is_illegal),
    .epc_val    (epc_val),
    .handler    (handler)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      esr          <= '0;
      epcr         <= '0;
      eear         <= '0;
      ppc          <= '0;
      status_we    <= 1'b0;
      status_wdata <= '0;
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
      err_flag     <= 1'b0;
      err_pc       <= '0;
    end else begin
      status_we    <= 1'b0;
      redirect_vld <= 1'b0;
      err_flag     <= 1'b0;
      if (exc_req) begin
        if (known) begin
          esr                       <= status_in;
          status_we                 <= 1'b1;
          status_wdata              <= status_in;
          status_wdata[ST_DSX_BIT]  <= pend_ds;
          redirect_vld              <= 1'b1;
          redirect_pc               <= handler;
          if (epc_load) epcr <= epc_val;
          if (is_illegal) eear <= exc_pc;
        end else begin
          err_flag <= 1'b1;
          err_pc   <= exc_pc;
        end
      end else if (rfe_req) begin
        status_we               <= 1'b1;
        status_wdata            <= esr;
        status_wdata[ST_FO_BIT] <= 1'b1;
        redirect_vld            <= 1'b1;
        redirect_pc             <= epcr;
      end else if (retire_vld) begin
        ppc <= retire_pc;
        if (bad_slot) begin
          err_flag <= 1'b1;
          err_pc   <= retire_pc;
        end
      end
    end
  end
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
  import trap_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned SW        = 16,
  parameter int unsigned CW        = 4,
  parameter int unsigned VEC_SHIFT = 8,
  parameter logic [AW-1:0] HI_BASE = 32'hF000_0000
) (
  input logic          clk,
  input logic          rst,
  input logic          retire_vld,
  input logic          retire_dly_cti,
  input logic          retire_no_ds,
  input logic          no_dslot_cfg,
  input logic          exc_req,
  input logic [CW-1:0] exc_code,
  input logic          rfe_req,
  input logic [SW-1:0] status_in,
  input logic          in_dslot,
  input logic          pend_ds,
  input logic          status_wdata_fo,
  input logic          err_flag,
  input logic          redirect_vld,
  input logic [AW-1:0] redirect_pc
);
  logic ret_only;
  logic exc_known;
  assign ret_only  = retire_vld & ~exc_req & ~rfe_req;
  assign exc_known = exc_req && (classify(4'(exc_code)) != CLS_NONE);

  assert_flag_advance_R1: assert property (@(posedge clk) disable iff (rst)
    ret_only |=> in_dslot == $past(pend_ds));

  assert_pending_set_R2: assert property (@(posedge clk) disable iff (rst)
    (ret_only && retire_dly_cti && !no_dslot_cfg) |=> pend_ds);

  assert_bad_slot_err_R3: assert property (@(posedge clk) disable iff (rst)
    (ret_only && pend_ds && retire_no_ds) |=> err_flag);

  assert_unknown_err_R7: assert property (@(posedge clk) disable iff (rst)
    (exc_req && !exc_known) |=> (err_flag && !redirect_vld));

  assert_handler_R9: assert property (@(posedge clk) disable iff (rst)
    exc_known |=> (redirect_vld && !pend_ds && redirect_pc ==
      (($past(status_in[ST_EPH_BIT]) ? HI_BASE : '0) + (AW'($past(exc_code)) << VEC_SHIFT))));

  assert_rfe_fo_R10: assert property (@(posedge clk) disable iff (rst)
    (rfe_req && !exc_req) |=> (status_wdata_fo && redirect_vld && !pend_ds && !in_dslot));

  assert_redirect_cause_R12: assert property (@(posedge clk) disable iff (rst)
    redirect_vld |-> $past(exc_req || rfe_req));
endmodule

bind trap_seq trap_seq_chk #(
  .AW(AW), .SW(SW), .CW(CW), .VEC_SHIFT(VEC_SHIFT), .HI_BASE(HI_BASE)
) u_trap_seq_chk (
  .clk             (clk),
  .rst             (rst),
  .retire_vld      (retire_vld),
  .retire_dly_cti  (retire_dly_cti),
  .retire_no_ds    (retire_no_ds),
  .no_dslot_cfg    (no_dslot_cfg),
  .exc_req         (exc_req),
  .exc_code        (exc_code),
  .rfe_req         (rfe_req),
  .status_in       (status_in),
  .in_dslot        (in_dslot),
  .pend_ds         (pend_ds),
  .status_wdata_fo (status_wdata[15]),
  .err_flag        (err_flag),
  .redirect_vld    (redirect_vld),
  .redirect_pc     (redirect_pc)
);

// File: tb/test_trap_seq.sv
module test_trap_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        retire_vld, retire_dly_cti, retire_no_ds, no_dslot_cfg;
  logic [31:0] retire_pc, exc_pc;
  logic        exc_req, rfe_req;
  logic [3:0]  exc_code;
  logic [15:0] status_in;
  logic [15:0] esr, status_wdata;
  logic [31:0] epcr, eear, ppc, redirect_pc, err_pc;
  logic        status_we, in_dslot, redirect_vld, err_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  trap_seq i_trap_seq (
    .clk(clk), .rst(rst),
    .retire_vld(retire_vld), .retire_pc(retire_pc),
    .retire_dly_cti(retire_dly_cti), .retire_no_ds(retire_no_ds),
    .no_dslot_cfg(no_dslot_cfg),
    .exc_req(exc_req), .exc_code(exc_code), .exc_pc(exc_pc),
    .rfe_req(rfe_req), .status_in(status_in),
    .esr(esr), .epcr(epcr), .eear(eear), .ppc(ppc),
    .status_we(status_we), .status_wdata(status_wdata),
    .in_dslot(in_dslot), .redirect_vld(redirect_vld),
    .redirect_pc(redirect_pc), .err_flag(err_flag), .err_pc(err_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    retire_vld = 0; retire_dly_cti = 0; retire_no_ds = 0;
    exc_req = 0; rfe_req = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic retire(input logic [31:0] pc, input logic cti, input logic nods);
    retire_vld = 1; retire_pc = pc; retire_dly_cti = cti; retire_no_ds = nods;
    tick();
  endtask

  task automatic raise(input logic [3:0] code, input logic [31:0] pc, input logic [15:0] st);
    exc_req = 1; exc_code = code; exc_pc = pc; status_in = st;
    tick();
  endtask

  task automatic t_reset();
    chk("R12 reset redirect", 32'(redirect_vld), 0);
    chk("R12 reset err", 32'(err_flag), 0);
    chk("R1 reset in_dslot", 32'(in_dslot), 0);
    chk("R4 reset esr", 32'(esr), 0);
  endtask

  task automatic t_slot_flags();
    retire(32'h100, 0, 0);
    chk("R11 ppc", ppc, 32'h100);
    chk("R1 plain", 32'(in_dslot), 0);
    retire(32'h200, 1, 0);
    chk("R1 branch itself", 32'(in_dslot), 0);
    retire(32'h204, 0, 0);
    chk("R2 slot marked", 32'(in_dslot), 1);
    retire(32'h208, 0, 0);
    chk("R1 after slot", 32'(in_dslot), 0);
  endtask

  task automatic t_no_dslot_cfg();
    no_dslot_cfg = 1;
    retire(32'h220, 1, 0);
    retire(32'h224, 0, 0);
    chk("R2 cfg suppresses", 32'(in_dslot), 0);
    no_dslot_cfg = 0;
  endtask

  task automatic t_forbidden();
    retire(32'h300, 1, 0);
    retire(32'h304, 0, 1);
    chk("R3 err", 32'(err_flag), 1);
    chk("R3 err_pc", err_pc, 32'h304);
    tick();
    chk("R12 err pulse", 32'(err_flag), 0);
    retire(32'h308, 0, 1);
    chk("R3 no err outside slot", 32'(err_flag), 0);
  endtask

  task automatic t_syscall();
    raise(4'hC, 32'h400, 16'h0001);
    chk("R5 epc +4", epcr, 32'h404);
    chk("R4 esr", 32'(esr), 32'h0001);
    chk("R4 status we", 32'(status_we), 1);
    chk("R4 dsx clear", 32'(status_wdata), 32'h0001);
    chk("R9 redirect", 32'(redirect_vld), 1);
    chk("R9 handler", redirect_pc, 32'h0000_0C00);
    tick();
    chk("R12 redirect pulse", 32'(redirect_vld), 0);
    retire(32'h500, 1, 0);
    raise(4'hC, 32'h504, 16'h0001);
    chk("R5 epc in slot", epcr, 32'h504);
    chk("R4 dsx set", 32'(status_wdata), 32'h2001);
    chk("R4 in_dslot", 32'(in_dslot), 1);
  endtask

  task automatic t_faults();
    retire(32'h600, 1, 0);
    raise(4'h6, 32'h604, 16'h0000);
    chk("R6 align in slot", epcr, 32'h600);
    retire(32'h608, 0, 0);
    chk("R9 pending cleared", 32'(in_dslot), 0);
    raise(4'hB, 32'h700, 16'h0000);
    chk("R6 range", epcr, 32'h700);
    chk("R9 range handler", redirect_pc, 32'h0000_0B00);
    raise(4'h7, 32'h800, 16'h4000);
    chk("R8 eear", eear, 32'h800);
    chk("R6 illegal epc", epcr, 32'h800);
    chk("R9 high base", redirect_pc, 32'hF000_0700);
  endtask

  task automatic t_rfe_reset_unknown();
    logic [15:0] esr_before;
    raise(4'hE, 32'h900, 16'h0022);
    chk("R6 trap epc", epcr, 32'h900);
    rfe_req = 1;
    tick();
    chk("R10 status", 32'(status_wdata), 32'h8022);
    chk("R10 we", 32'(status_we), 1);
    chk("R10 target", redirect_pc, 32'h900);
    raise(4'h1, 32'hA00, 16'h0005);
    chk("R7 reset epc kept", epcr, 32'h900);
    chk("R9 reset handler", redirect_pc, 32'h100);
    esr_before = esr;
    raise(4'h3, 32'hB00, 16'h0077);
    chk("R7 unknown err", 32'(err_flag), 1);
    chk("R7 unknown err_pc", err_pc, 32'hB00);
    chk("R7 no redirect", 32'(redirect_vld), 0);
    chk("R7 no status write", 32'(status_we), 0);
    chk("R7 esr kept", 32'(esr), 32'(esr_before));
    chk("R7 epc kept", epcr, 32'h900);
    retire(32'hC00, 1, 0);
    rfe_req = 1;
    tick();
    retire(32'hC08, 0, 0);
    chk("R10 pending cleared", 32'(in_dslot), 0);
  endtask

  task automatic t_priority();
    retire(32'hD00, 0, 0);
    retire_vld = 1; retire_pc = 32'hD04; retire_dly_cti = 1;
    exc_req = 1; exc_code = 4'hE; exc_pc = 32'hD04; status_in = 16'h0;
    tick();
    chk("R12 retire ignored ppc", ppc, 32'hD00);
    chk("R12 exc won", epcr, 32'hD04);
    retire(32'hD08, 0, 0);
    chk("R12 no pending", 32'(in_dslot), 0);
    retire_vld = 1; retire_pc = 32'hE00; rfe_req = 1;
    tick();
    chk("R12 rfe over retire", ppc, 32'hD08);
  endtask

  initial begin
    idle();
    rst = 1; no_dslot_cfg = 0; status_in = 0;
    retire_pc = 0; exc_pc = 0; exc_code = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_slot_flags();
    t_no_dslot_cfg();
    t_forbidden();
    t_syscall();
    t_faults();
    t_rfe_reset_unknown();
    t_priority();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule